// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Aligner

This block connects a processor's load/store stage to a data memory that is one 64-bit word (eight byte lanes, little-endian) wide. A request carries a byte address, an access size of 1, 2, 4 or 8 bytes, a byte-reverse flag and, for stores, write data. For a load, the block reads the word that holds the address. It cuts out the addressed bytes and returns them right-justified and zero-extended, reversed if requested. For a store, the block moves the data into the addressed lanes and writes them through a per-byte write-enable mask, so the other lanes of the word keep their contents without a read-modify-write cycle.

Alignment is checked when a request is accepted. A misaligned load always faults. A misaligned store faults unless the split-store mode input is high. In that mode, a store that fits inside one word is written as it is. A store that runs past the end of its word becomes two back-to-back writes: the lower word first, then the next word. A fault writes nothing, gives a one-cycle pulse and latches the full byte address.

Top module: `lsu_lane_align`

## Requirements
- R1: For a request accepted in cycle N, the memory is accessed in cycle N with `mem_word_addr` equal to `req_addr >> 3`. The byte offset inside the word is `req_addr & 7`.
- R2: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An aligned load accepted in cycle N gives `ld_valid` high in cycle N+1. In that cycle `ld_data` byte i equals the memory byte at address `req_addr + i` for i below the size, and the bits above are zero.
- R3: With `req_swap` high, a load returns its size-wide value with the byte order reversed (byte i becomes byte size−1−i). The upper bits stay zero.
- R4: An aligned store is one write in its acceptance cycle. `mem_be` bit k is set exactly for lanes offset to offset+size−1, and lane offset+i of `mem_wdata` carries data byte i. Lanes that are not enabled keep their memory contents.
- R5: With `req_swap` high, the store data is byte-reversed within its size before it is placed into lanes. The reversal is applied once, before any split.
- R6: A load whose offset AND (size−1) is nonzero makes no memory access. It gives `fault_pulse` high for exactly cycle N+1, with `fault_addr` equal to the full request address, in every mode.
- R7: With `split_ok` low, a misaligned store is refused in the same way as R6 and writes nothing.
- R8: With `split_ok` high, a misaligned store whose offset plus size is at most 8 is written as one write, with the lanes and data of R4.
- R9: With `split_ok` high, a store whose offset plus size exceeds 8 writes lanes offset..7 of word W in cycle N with the first 8−offset data bytes. In cycle N+1 it writes the remaining bytes to lanes 0 and up of word W+1. `req_ready` is low in cycle N+1.
- R10: `fault_addr` keeps its value until the next fault.
- R11: While reset is held, and after it, `req_ready` is high and `mem_en`, `ld_valid` and `fault_pulse` are low. `fault_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code (0..3 → 1, 2, 4, 8 bytes) |
| req_swap | input | 1 | Reverse the byte order of the value |
| req_wdata | input | 64 | Store data, right-justified |
| split_ok | input | 1 | Allow misaligned stores, split at word boundaries |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (with mem_en) |
| mem_word_addr | output | ADDR_W-3 | Word index |
| mem_be | output | 8 | Per-lane write enable |
| mem_wdata | output | 64 | Lane-placed write data |
| mem_rdata | input | 64 | Read word, one cycle after the read strobe |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Right-justified load result |
| fault_pulse | output | 1 | One-cycle alignment fault indication |
| fault_addr | output | ADDR_W | Address of the last faulting request |

## Verification
The memory strobe, word address, lane enables and lane data of a request are combinational in its acceptance cycle. The bench therefore drives each request just after a falling edge and checks these outputs one nanosecond later, before the rising edge that accepts it. Load data, the fault pulse and the fault address are due one rising edge after acceptance, so they are checked at the next falling edge. The second half of a split store is checked in that same later cycle, together with the low `req_ready`. `fault_pulse` is checked again one cycle after that, to confirm it has dropped. Every store is then read back with full-word loads and compared against a byte-array model, which shows that untouched lanes kept their contents.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    localparam int LANES = 8;
    localparam int OFS_W = 3;
    localparam int DW    = LANES * 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        size_e            size;
        logic             swap;
    } ld_ctx_t;

    typedef struct packed {
        logic [2*LANES-1:0] be;
        logic [2*DW-1:0]    data;
    } st_lanes_t;

    function automatic int size_bytes(input size_e s);
        return 1 << int'(s);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input size_e s);
        logic [LANES-1:0] m;
        int n;
        n = size_bytes(s);
        for (int i = 0; i < LANES; i++) m[i] = (i < n);
        return m;
    endfunction

    function automatic logic [DW-1:0] expand_mask(input logic [LANES-1:0] m);
        logic [DW-1:0] e;
        for (int i = 0; i < LANES; i++) e[i*8 +: 8] = {8{m[i]}};
        return e;
    endfunction

    function automatic logic [DW-1:0] swap_bytes(input logic [DW-1:0] d, input size_e s);
        logic [DW-1:0] r;
        int n;
        r = '0;
        n = size_bytes(s);
        for (int i = 0; i < LANES; i++) begin
            if (i < n) r[i*8 +: 8] = d[(n-1-i)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_align_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  size_e            size,
    input  logic             is_store,
    input  logic             split_ok,
    output logic             fault
);
    logic [OFS_W-1:0] low_bits;
    logic             misaligned;

    always_comb begin
        low_bits   = OFS_W'(size_bytes(size) - 1);
        misaligned = |(ofs & low_bits);
        fault      = misaligned && (!is_store || !split_ok);
    end
endmodule

// File: rtl/lsu_store_place.sv
module lsu_store_place
    import lsu_align_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  size_e            size,
    input  logic             swap,
    input  logic [DW-1:0]    wdata,
    output st_lanes_t        lanes,
    output logic             crosses
);
    logic [DW-1:0] ordered;
    logic [DW-1:0] trimmed;

    always_comb begin
        ordered     = swap ? swap_bytes(wdata, size) : wdata;
        trimmed     = ordered & expand_mask(lane_mask(size));
        lanes.data  = {{DW{1'b0}}, trimmed} << {ofs, 3'b000};
        lanes.be    = {{LANES{1'b0}}, lane_mask(size)} << ofs;
        crosses     = |lanes.be[2*LANES-1:LANES];
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take_load,
    input  logic [OFS_W-1:0] ofs,
    input  size_e            size,
    input  logic             swap,
    input  logic [DW-1:0]    mem_rdata,
    output logic             ld_valid,
    output logic [DW-1:0]    ld_data
);
    ld_ctx_t       ctx;
    logic [DW-1:0] shifted;
    logic [DW-1:0] cut;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid <= 1'b0;
            ctx      <= '0;
        end else begin
            ld_valid <= take_load;
            if (take_load) begin
                ctx.ofs  <= ofs;
                ctx.size <= size;
                ctx.swap <= swap;
            end
        end
    end

    always_comb begin
        shifted = mem_rdata >> {ctx.ofs, 3'b000};
        cut     = shifted & expand_mask(lane_mask(ctx.size));
        ld_data = ctx.swap ? swap_bytes(cut, ctx.size) : cut;
    end

    // R3: a returned value never carries bits above its size
    assert_ld_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> ((ld_data & ~expand_mask(lane_mask(ctx.size))) == '0));
endmodule

// File: rtl/lsu_split_seq.sv
module lsu_split_seq
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int WORD_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_split,
    input  logic              raise_fault,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  hi_be,
    input  logic [DW-1:0]     hi_data,
    output logic              busy,
    output logic [WORD_W-1:0] hold_word,
    output logic [LANES-1:0]  hold_be,
    output logic [DW-1:0]     hold_data,
    output logic              fault_pulse,
    output logic [ADDR_W-1:0] fault_addr
);
    typedef enum logic {ST_IDLE, ST_UPPER} seq_e;
    seq_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            hold_word   <= '0;
            hold_be     <= '0;
            hold_data   <= '0;
            fault_pulse <= 1'b0;
            fault_addr  <= '0;
        end else begin
            fault_pulse <= raise_fault;
            if (raise_fault) fault_addr <= req_addr;
            case (state)
                ST_IDLE: if (start_split) begin
                    state     <= ST_UPPER;
                    hold_word <= req_addr[ADDR_W-1:OFS_W] + 1'b1;
                    hold_be   <= hi_be;
                    hold_data <= hi_data;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_UPPER);

    // R9: the upper half occupies exactly one cycle
    assert_upper_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
    // R6: the latched address belongs to the refused request
    assert_fault_addr_capture_R6: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> fault_addr == $past(req_addr));
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int WORD_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_swap,
    input  logic [DW-1:0]     req_wdata,
    input  logic              split_ok,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_word_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              ld_valid,
    output logic [DW-1:0]     ld_data,
    output logic              fault_pulse,
    output logic [ADDR_W-1:0] fault_addr
);
    size_e             size;
    logic [OFS_W-1:0]  ofs;
    logic              accept;
    logic              fault_now;
    logic              crosses;
    logic              busy;
    st_lanes_t         lanes;
    logic [WORD_W-1:0] hold_word;
    logic [LANES-1:0]  hold_be;
    logic [DW-1:0]     hold_data;

    assign size      = size_e'(req_size);
    assign ofs       = req_addr[OFS_W-1:0];
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    lsu_align_check u_check (
        .ofs      (ofs),
        .size     (size),
        .is_store (req_store),
        .split_ok (split_ok),
        .fault    (fault_now)
    );

    lsu_store_place u_place (
        .ofs     (ofs),
        .size    (size),
        .swap    (req_swap),
        .wdata   (req_wdata),
        .lanes   (lanes),
        .crosses (crosses)
    );

    lsu_load_extract u_load (
        .clk       (clk),
        .rst       (rst),
        .take_load (accept && !req_store && !fault_now),
        .ofs       (ofs),
        .size      (size),
        .swap      (req_swap),
        .mem_rdata (mem_rdata),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data)
    );

    lsu_split_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_split (accept && req_store && !fault_now && crosses),
        .raise_fault (accept && fault_now),
        .req_addr    (req_addr),
        .hi_be       (lanes.be[2*LANES-1:LANES]),
        .hi_data     (lanes.data[2*DW-1:DW]),
        .busy        (busy),
        .hold_word   (hold_word),
        .hold_be     (hold_be),
        .hold_data   (hold_data),
        .fault_pulse (fault_pulse),
        .fault_addr  (fault_addr)
    );

    always_comb begin
        if (busy) begin
            mem_en        = 1'b1;
            mem_we        = 1'b1;
            mem_word_addr = hold_word;
            mem_be        = hold_be;
            mem_wdata     = hold_data;
        end else begin
            mem_en        = accept && !fault_now;
            mem_we        = req_store;
            mem_word_addr = req_addr[ADDR_W-1:OFS_W];
            mem_be        = req_store ? lanes.be[LANES-1:0] : '0;
            mem_wdata     = lanes.data[DW-1:0];
        end
    end

    // R6 / R7: a refused request never reaches the memory
    assert_fault_blocks_mem_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && fault_now) |-> !mem_en);
    // R9: the upper write goes to the following word while requests are held off
    assert_upper_next_word_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mem_we && !req_ready && mem_word_addr == $past(req_addr[ADDR_W-1:OFS_W]) + 1'b1));
    // R4: every write enables at least one lane
    assert_write_has_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |-> mem_be != '0);
    // R2: a result follows a read strobe by one cycle
    assert_ld_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(mem_en && !mem_we));
    // R10: the fault address only moves with a fault
    assert_fault_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !fault_pulse |-> $stable(fault_addr));
endmodule

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_swap = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        split_ok = 1'b0;
    logic        mem_en, mem_we;
    logic [28:0] mem_word_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        ld_valid;
    logic [63:0] ld_data;
    logic        fault_pulse;
    logic [31:0] fault_addr;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    logic [63:0] mem_words [16];
    logic [7:0]  ref_mem   [128];

    always #10 clk = ~clk;

    lsu_lane_align u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_addr(req_addr), .req_size(req_size),
        .req_swap(req_swap), .req_wdata(req_wdata), .split_ok(split_ok),
        .mem_en(mem_en), .mem_we(mem_we), .mem_word_addr(mem_word_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .fault_pulse(fault_pulse),
        .fault_addr(fault_addr)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int k = 0; k < 8; k++)
                    if (mem_be[k]) mem_words[mem_word_addr[3:0]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
            end else begin
                mem_rdata <= mem_words[mem_word_addr[3:0]];
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [1:0] size_code(input int n);
        return (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : (n == 4) ? 2'd2 : 2'd3;
    endfunction

    task automatic do_load(input logic [31:0] a, input int n, input bit sw, input string rq);
        logic [63:0] e = '0;
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) e[i*8 +: 8] = ref_mem[a[6:0] + 7'(i)];
        if (sw) begin
            for (int i = 0; i < n; i++) r[i*8 +: 8] = e[(n-1-i)*8 +: 8];
            e = r;
        end
        @(negedge clk);
        req_valid = 1; req_store = 0; req_addr = a; req_size = size_code(n); req_swap = sw;
        #1;
        chk(mem_en && !mem_we, "R1", "read strobe", {62'b0, mem_en, mem_we}, 64'h2);
        chk(mem_word_addr == a[31:3], "R1", "word address", 64'(mem_word_addr), 64'(a[31:3]));
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk(ld_valid == 1'b1, rq, "ld_valid", 64'(ld_valid), 64'h1);
        chk(ld_data == e, rq, "ld_data", ld_data, e);
    endtask

    task automatic do_store(input logic [31:0] a, input int n, input bit sw,
                            input logic [63:0] d, input bit allow, input string rq);
        logic [7:0]  sb [8];
        logic [15:0] be_all;
        int          ofs = int'(a[2:0]);
        for (int i = 0; i < n; i++) sb[i] = sw ? d[(n-1-i)*8 +: 8] : d[i*8 +: 8];
        be_all = ((16'h1 << n) - 16'h1) << ofs;
        @(negedge clk);
        req_valid = 1; req_store = 1; req_addr = a; req_size = size_code(n);
        req_swap = sw; req_wdata = d; split_ok = allow;
        #1;
        chk(mem_en && mem_we, rq, "first write strobe", {62'b0, mem_en, mem_we}, 64'h3);
        chk(mem_word_addr == a[31:3], rq, "first word", 64'(mem_word_addr), 64'(a[31:3]));
        chk(mem_be == be_all[7:0], rq, "first lanes", 64'(mem_be), 64'(be_all[7:0]));
        for (int i = 0; i < n; i++)
            if (ofs + i < 8)
                chk(mem_wdata[(ofs+i)*8 +: 8] == sb[i], rq, "first lane data",
                    64'(mem_wdata[(ofs+i)*8 +: 8]), 64'(sb[i]));
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        #1;
        if (be_all[15:8] != 0) begin
            chk(!req_ready && mem_en && mem_we, "R9", "upper write, ready low",
                {61'b0, req_ready, mem_en, mem_we}, 64'h3);
            chk(mem_word_addr == a[31:3] + 1, "R9", "upper word",
                64'(mem_word_addr), 64'(a[31:3] + 1));
            chk(mem_be == be_all[15:8], "R9", "upper lanes", 64'(mem_be), 64'(be_all[15:8]));
            for (int i = 0; i < n; i++)
                if (ofs + i >= 8)
                    chk(mem_wdata[(ofs+i-8)*8 +: 8] == sb[i], "R9", "upper lane data",
                        64'(mem_wdata[(ofs+i-8)*8 +: 8]), 64'(sb[i]));
            @(posedge clk);
            @(negedge clk);
            #1;
        end else begin
            chk(!mem_en, rq, "single write only", 64'(mem_en), 64'h0);
        end
        chk(req_ready, rq, "ready after store", 64'(req_ready), 64'h1);
        for (int i = 0; i < n; i++) ref_mem[a[6:0] + 7'(i)] = sb[i];
    endtask

    task automatic do_fault(input logic [31:0] a, input int n, input bit st,
                            input bit allow, input string rq);
        @(negedge clk);
        req_valid = 1; req_store = st; req_addr = a; req_size = size_code(n);
        req_swap = 0; req_wdata = 64'hDEAD_BEEF_CAFE_F00D; split_ok = allow;
        #1;
        chk(!mem_en, rq, "no memory access on fault", 64'(mem_en), 64'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk(fault_pulse && !ld_valid, rq, "fault pulse",
            {62'b0, fault_pulse, ld_valid}, 64'h2);
        chk(fault_addr == a, rq, "fault address", 64'(fault_addr), 64'(a));
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(!fault_pulse, "R6", "pulse lasts one cycle", 64'(fault_pulse), 64'h0);
    endtask

    task automatic verify_words(input int first, input int last, input string rq);
        for (int w = first; w <= last; w++) do_load(32'(w * 8), 8, 0, rq);
    endtask

    task automatic t_reset;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(req_ready && !mem_en && !ld_valid && !fault_pulse, "R11", "outputs in reset",
            {60'b0, req_ready, mem_en, ld_valid, fault_pulse}, 64'h8);
        chk(fault_addr == 0, "R11", "fault address in reset", 64'(fault_addr), 64'h0);
        rst = 0;
        @(negedge clk);
        #1;
        chk(req_ready && !mem_en, "R11", "idle after reset", {62'b0, req_ready, mem_en}, 64'h2);
    endtask

    task automatic t_aligned;
        do_store(32'h08, 8, 0, 64'h8877_6655_4433_2211, 0, "R4");
        do_load(32'h08, 8, 0, "R2");
        do_load(32'h0B, 1, 0, "R2");
        do_load(32'h0C, 2, 0, "R2");
        do_load(32'h0C, 4, 0, "R2");
        do_load(32'h18, 8, 0, "R2");
    endtask

    task automatic t_swap;
        do_load(32'h08, 4, 1, "R3");
        do_load(32'h0E, 2, 1, "R3");
        do_store(32'h0A, 2, 0, 64'h0000_0000_0000_BEEF, 0, "R4");
        verify_words(1, 1, "R4");
        do_store(32'h10, 4, 1, 64'h0000_0000_A1B2_C3D4, 0, "R5");
        do_load(32'h10, 4, 0, "R5");
    endtask

    task automatic t_faults;
        do_fault(32'h09, 2, 0, 0, "R6");
        do_fault(32'h22, 4, 1, 0, "R7");
        verify_words(4, 4, "R7");
        do_load(32'h08, 1, 0, "R10");
        chk(fault_addr == 32'h22, "R10", "fault address held", 64'(fault_addr), 64'h22);
        do_fault(32'h13, 4, 0, 1, "R6");
    endtask

    task automatic t_split;
        do_store(32'h21, 4, 0, 64'h0000_0000_4433_2211, 1, "R8");
        verify_words(4, 4, "R8");
        do_store(32'h2D, 8, 0, 64'h0807_0605_0403_0201, 1, "R9");
        verify_words(5, 6, "R9");
        do_store(32'h3E, 4, 1, 64'h0000_0000_1122_3344, 1, "R5");
        verify_words(7, 8, "R9");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem_words[i] = '0;
        for (int i = 0; i < 128; i++) ref_mem[i] = '0;
        t_reset();
        t_aligned();
        t_swap();
        t_faults();
        t_split();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule